// File: doc/BRIEF.md
# Reloading Prescaled Event Counter

This block holds two counters driven by a single-cycle tick strobe. A down-counter loses one on each tick while it is nonzero. On the tick that finds it at zero, it takes a programmable reload value, and an up-counter advances by one on that same tick. The up-counter therefore counts the reload periods that have elapsed. When the reload value is zero, the down-counter stays at zero and the up-counter advances on every tick. The tick is expected at a nominal 20 MHz rate, but it arrives here as a strobe from logic outside the block.

Software reaches the reload value, the down-counter and the up-counter through a small register port. It can overwrite any one of them at any time. A write does not stall or reset the counting: a tick in the same cycle still updates the register that is not being written. Reads go through a registered multiplexer and return data one cycle after the select is presented.

Top module: `presc_evt_counter`

## Requirements
- R1: After synchronous reset the reload value, the down-counter, the up-counter and `rd_data` are all zero.
- R2: A tick while the down-counter is nonzero lowers it by exactly one. Without a tick or a write, the down-counter holds its value.
- R3: A tick while the down-counter is zero loads it with the reload value and adds one to the up-counter in the same cycle. For example, reload 5 from a start of 7 gives 7,6,5,4,3,2,1,0,5,4,3,2,1,0,5, with two up-counter increments.
- R4: With a reload value of zero, a down-counter at zero stays at zero, and the up-counter increases by one on every tick.
- R5: The up-counter changes only on a wrapping tick or a write. It wraps from all ones to zero with no flag.
- R6: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_sel`, and the value can be read from the next cycle on. The encoding is 0 = reload value, 1 = down-counter, 2 = up-counter.
- R7: If a write and a tick fall in the same cycle, the written register takes the written value. The other counter still updates from the tick, using the state held before that cycle. A tick that reloads in the same cycle as a reload-value write uses the old reload value.
- R8: `rd_data` shows, one cycle later, the register chosen by `rd_sel` (same encoding as R6) as it stood before the clock edge. Select 3 reads zero, and a write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescale tick strobe, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 reload, 1 down-counter, 2 up-counter, 3 none |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Read source, same encoding as `wr_sel` |
| rd_data | output | CNT_W | Registered read data, one cycle latency |

## Verification
The bench sweeps small reload values and start values through irregular tick patterns. It compares both counters after every step against an arithmetic model. This exposes an off-by-one reload: a design that reloads on the tick that reaches zero, instead of the tick after, would produce periods one tick short. Zero reload is swept as its own case, because a design that stalls there would leave the up-counter frozen instead of counting every tick. Write-versus-tick collisions are hit on each register at both zero and nonzero down-counter values. A design that let the tick override a write, or that dropped the other counter's update, shows up as a wrong count. Up-counter wrap, the unused select, and read latency under a simultaneous tick are checked directly.

// File: rtl/presc_evt_pkg.sv
package presc_evt_pkg;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_DOWN   = 2'd1,
        SEL_UP     = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rel;
        logic down;
        logic up;
    } wr_hit_t;

    function automatic wr_hit_t decode_write(input logic en, input reg_sel_e sel);
        wr_hit_t h;
        h      = '0;
        h.rel  = en && (sel == SEL_RELOAD);
        h.down = en && (sel == SEL_DOWN);
        h.up   = en && (sel == SEL_UP);
        return h;
    endfunction

endpackage

// File: rtl/presc_evt_reload.sv
module presc_evt_reload
    import presc_evt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_hit_t          wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] reload_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (wr_hit.rel) begin
            reload_q <= wr_data;
        end
    end
endmodule

// File: rtl/presc_evt_down.sv
module presc_evt_down
    import presc_evt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  wr_hit_t          wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] down_q,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             at_zero;
    logic [CNT_W-1:0] down_d;

    assign at_zero = (down_q == '0);
    assign wrap    = tick && at_zero;

    always_comb begin
        down_d = down_q;
        if (tick) begin
            down_d = at_zero ? reload_q : (down_q - ONE);
        end
        if (wr_hit.down) begin
            down_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            down_q <= '0;
        end else begin
            down_q <= down_d;
        end
    end
endmodule

// File: rtl/presc_evt_up.sv
module presc_evt_up
    import presc_evt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap,
    input  wr_hit_t          wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] up_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= '0;
        end else if (wr_hit.up) begin
            up_q <= wr_data;
        end else if (wrap) begin
            up_q <= up_q + ONE;
        end
    end
endmodule

// File: rtl/presc_evt_rdmux.sv
module presc_evt_rdmux
    import presc_evt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_sel_e         rd_sel,
    input  logic [CNT_W-1:0] reload_q,
    input  logic [CNT_W-1:0] down_q,
    input  logic [CNT_W-1:0] up_q,
    output logic [CNT_W-1:0] rd_data
);
    logic [CNT_W-1:0] rd_d;

    always_comb begin
        unique case (rd_sel)
            SEL_RELOAD: rd_d = reload_q;
            SEL_DOWN:   rd_d = down_q;
            SEL_UP:     rd_d = up_q;
            default:    rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_d;
        end
    end
endmodule

// File: rtl/presc_evt_counter.sv
module presc_evt_counter
    import presc_evt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data
);
    wr_hit_t          wr_hit;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] down_q;
    logic [CNT_W-1:0] up_q;
    logic             wrap;

    assign wr_hit = decode_write(wr_en, reg_sel_e'(wr_sel));

    presc_evt_reload #(.CNT_W(CNT_W)) u_reload (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_hit),
        .wr_data  (wr_data),
        .reload_q (reload_q)
    );

    presc_evt_down #(.CNT_W(CNT_W)) u_down (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_hit   (wr_hit),
        .wr_data  (wr_data),
        .reload_q (reload_q),
        .down_q   (down_q),
        .wrap     (wrap)
    );

    presc_evt_up #(.CNT_W(CNT_W)) u_up (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .wr_hit  (wr_hit),
        .wr_data (wr_data),
        .up_q    (up_q)
    );

    presc_evt_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .clk      (clk),
        .rst      (rst),
        .rd_sel   (reg_sel_e'(rd_sel)),
        .reload_q (reload_q),
        .down_q   (down_q),
        .up_q     (up_q),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/presc_evt_counter_chk.sv
module presc_evt_counter_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [1:0]       rd_sel,
    input logic [CNT_W-1:0] rd_data,
    input logic [CNT_W-1:0] reload_q,
    input logic [CNT_W-1:0] down_q,
    input logic [CNT_W-1:0] up_q
);
    logic w_rel, w_down, w_up;
    assign w_rel  = wr_en && (wr_sel == 2'd0);
    assign w_down = wr_en && (wr_sel == 2'd1);
    assign w_up   = wr_en && (wr_sel == 2'd2);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (reload_q == '0 && down_q == '0 && up_q == '0 && rd_data == '0));

    // R2
    down_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !w_down && down_q != '0) |=> (down_q == $past(down_q) - 1'b1));

    // R2
    down_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !w_down) |=> $stable(down_q));

    // R3
    down_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !w_down && down_q == '0) |=> (down_q == $past(reload_q)));

    // R3
    up_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !w_up && down_q == '0) |=> (up_q == $past(up_q) + 1'b1));

    // R4
    stick_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !w_down && down_q == '0 && reload_q == '0) |=> (down_q == '0));

    // R5
    up_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(tick && down_q == '0) && !w_up) |=> $stable(up_q));

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !w_up && down_q == '0 && up_q == '1) |=> (up_q == '0));

    // R6
    wr_reload_chk: assert property (@(posedge clk) disable iff (rst)
        w_rel |=> (reload_q == $past(wr_data)));

    // R7
    wr_down_wins_chk: assert property (@(posedge clk) disable iff (rst)
        w_down |=> (down_q == $past(wr_data)));

    // R7
    wr_up_wins_chk: assert property (@(posedge clk) disable iff (rst)
        w_up |=> (up_q == $past(wr_data)));

    // R8
    rd_none_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd3) |=> (rd_data == '0));

    // R8
    rd_up_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd2) |=> (rd_data == $past(up_q)));
endmodule

bind presc_evt_counter presc_evt_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .reload_q (reload_q),
    .down_q   (down_q),
    .up_q     (up_q)
);

// File: tb/presc_evt_counter_tb.sv
module presc_evt_counter_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_sel = 2'd0;
    logic [W-1:0] rd_data;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic [W-1:0] m_rel = '0, m_down = '0, m_up = '0;

    always #4 clk = ~clk;

    presc_evt_counter #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic clk_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; model follows the requirements R2..R7
    task automatic apply(input logic t, input logic w, input logic [1:0] s, input logic [W-1:0] d);
        logic [W-1:0] nr, nd, nu;
        nr = m_rel; nd = m_down; nu = m_up;
        if (t) begin
            if (m_down == '0) begin nd = m_rel; nu = m_up + 1; end
            else nd = m_down - 1;
        end
        if (w) begin
            case (s)
                2'd0: nr = d;
                2'd1: nd = d;
                2'd2: nu = d;
                default: ;
            endcase
        end
        tick = t; wr_en = w; wr_sel = s; wr_data = d;
        clk_step();
        tick = 1'b0; wr_en = 1'b0;
        m_rel = nr; m_down = nd; m_up = nu;
    endtask

    task automatic read_reg(input logic [1:0] s, output logic [W-1:0] v);
        rd_sel = s;
        clk_step();
        v = rd_data;
    endtask

    task automatic verify_all(input string req);
        logic [W-1:0] v;
        read_reg(2'd0, v); check({req, " reload"}, v, m_rel);
        read_reg(2'd1, v); check({req, " down"}, v, m_down);
        read_reg(2'd2, v); check({req, " up"}, v, m_up);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] seq [15];
        @(negedge clk); clk_step(); clk_step();
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, rd_data before any read select changes
        check("R1 rd_data", rd_data, '0);
        verify_all("R1");

        // R3 worked example: reload 5 from start 7
        seq = '{7,6,5,4,3,2,1,0,5,4,3,2,1,0,5};
        apply(0, 1, 2'd0, 5);
        apply(0, 1, 2'd1, 7);
        apply(0, 1, 2'd2, 0);
        for (int k = 0; k < 15; k++) begin
            read_reg(2'd1, v);
            check("R3 sequence", v, seq[k]);
            if (k < 14) apply(1, 0, 2'd0, 0);
        end
        read_reg(2'd2, v);
        check("R3 two increments", v, 2);

        // R2/R3/R4 sweep over small reload and start values, irregular ticks
        for (int rel = 0; rel < 6; rel++) begin
            for (int st = 0; st < 7; st++) begin
                apply(0, 1, 2'd0, W'(rel));
                apply(0, 1, 2'd1, W'(st));
                apply(0, 1, 2'd2, W'(rel * 1000 + st));
                for (int k = 0; k < 16; k++) begin
                    apply((k % 4) != 3, 0, 2'd0, 0);
                    verify_all(rel == 0 ? "R4 sweep" : "R2/R3 sweep");
                end
            end
        end

        // R5: wrap of the up-counter, and hold with no tick
        apply(0, 1, 2'd0, 3);
        apply(0, 1, 2'd1, 0);
        apply(0, 1, 2'd2, 32'hFFFF_FFFF);
        apply(1, 0, 2'd0, 0);
        verify_all("R5 wrap");
        apply(0, 0, 2'd0, 0);
        apply(0, 0, 2'd0, 0);
        verify_all("R5 hold");

        // R7: write down-counter with tick, down nonzero (up unchanged)
        apply(0, 1, 2'd1, 4);
        apply(1, 1, 2'd1, 9);
        verify_all("R7 down write, nonzero");
        // R7: write down-counter with tick at zero (up still advances)
        apply(0, 1, 2'd1, 0);
        apply(1, 1, 2'd1, 11);
        verify_all("R7 down write, zero");
        // R7: write up-counter with tick at zero (down reloads)
        apply(0, 1, 2'd1, 0);
        apply(1, 1, 2'd2, 32'h1234);
        verify_all("R7 up write");
        // R7: write reload with tick at zero (old reload used)
        apply(0, 1, 2'd0, 6);
        apply(0, 1, 2'd1, 0);
        apply(1, 1, 2'd0, 2);
        verify_all("R7 reload write");
        // R6: plain writes
        apply(0, 1, 2'd0, 32'hA5A5_0001);
        apply(0, 1, 2'd1, 32'h0000_0100);
        apply(0, 1, 2'd2, 32'hCAFE_0000);
        verify_all("R6 write");

        // R8: select 3 reads zero and writes there do nothing
        read_reg(2'd3, v);
        check("R8 sel3 read", v, '0);
        apply(0, 1, 2'd3, 32'hDEAD_BEEF);
        verify_all("R8 sel3 write");

        // R8: read latency against a simultaneous tick
        apply(0, 1, 2'd1, 3);
        rd_sel = 2'd1;
        apply(1, 0, 2'd0, 0);
        check("R8 pre-tick value", rd_data, 3);
        clk_step();
        check("R8 post-tick value", rd_data, 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule